// File: doc/BRIEF.md
# Page-Table Transfer Sequencer

This block runs a serial-bus data transfer that is described by an SBP-2 style page table, with no processor help once it has started. Software sets a table address, a table size, a speed code, a payload code and a first element index, then pulses a start command. The sequencer reads the page elements through a memory read port and keeps them in local storage. It then walks the elements in order. For each element it issues one block transfer request per payload-sized chunk and waits for that chunk's completion before it issues the next.

A direct mode uses no table: the size input is taken as the byte length of one contiguous transfer at the table address. The fetch can be skipped so that elements already held are reused, and the walk can begin at any element. Pause stops the walk at the next boundary between transactions. A failed completion stops it at once and records a cause code. Resume continues after a pause, and after an error it re-issues the failed transaction unchanged. A reset command returns the sequencer to idle and leaves every status value as it was.

Top module: `pt_xfer_seq`

## Requirements
- R1: In table mode without skip, start causes 2·N reads, where N is the table size. Word k is read at table address + 4·k. Word 2i holds element i's segment length in bits 31:16 and address bits 47:32 in bits 15:0. Word 2i+1 holds address bits 31:0.
- R2: A segment is sent as chunks in ascending address order. Each chunk is min(2^(payload code + 2), bytes left). Codes whose payload does not fit in 16 bits send the whole remainder. Elements run in index order, and an element of length zero produces no request.
- R3: A table-mode start with a table size above MAX_ELEM (24) issues no request, keeps the sequencer idle and sets `st_err` to 4'hF.
- R4: In direct mode the transfer is one segment of `cfg_table_size` bytes at `cfg_table_addr`, with no reads. Size zero finishes at once.
- R5: With `cfg_skip_fetch` set, no reads are made and the stored elements from `cfg_start_elem` up to N-1 are sent.
- R6: Pause takes effect at the next transaction boundary: the sequencer enters state 6 and issues no request until `cmd_resume`, then continues where it stopped.
- R7: A completion with `cpl_err` set moves the sequencer on that edge to state 7, latches `cpl_code` into `st_err` and issues no further request.
- R8: Resume from state 7 re-issues the failed chunk with the same address and length.
- R9: `cmd_reset` returns the state to idle (0) at the next edge and drops any request. `st_err`, `st_elem` and `st_remain` keep their values.
- R10: `st_state` encodes idle 0, fetch request 1, fetch wait 2, element load 3, transfer request 4, transfer wait 5, paused 6 and error pause 7. `st_elem` is the current element index. `st_remain` is the bytes of that element not yet completed.
- R11: Two edges after the completion of the last chunk, `done` is set and `done_pulse` is high for exactly one cycle. A new start clears `done`.
- R12: `rd_valid` and `xf_valid` stay high, with stable address and length, until accepted by their ready. Read data is taken only in state 2, and completions only in state 5.
- R13: While `rst_n` is low, every status output and request is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_table_addr | input | 48 | Table address, or the data address in direct mode |
| cfg_table_size | input | 16 | Element count, or byte length in direct mode |
| cfg_speed | input | 3 | Speed code passed with every request |
| cfg_pay_code | input | 4 | Payload size code |
| cfg_start_elem | input | IDX_W | First element to transfer |
| cfg_direct | input | 1 | Direct (no table) mode |
| cfg_skip_fetch | input | 1 | Reuse stored elements |
| cmd_start | input | 1 | Start pulse |
| cmd_pause | input | 1 | Pause pulse |
| cmd_resume | input | 1 | Resume pulse |
| cmd_reset | input | 1 | Sequencer reset pulse |
| rd_valid | output | 1 | Table read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 48 | Read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data word |
| xf_valid | output | 1 | Block transfer request |
| xf_ready | input | 1 | Transfer request accepted |
| xf_addr | output | 48 | Chunk address |
| xf_len | output | 16 | Chunk length in bytes |
| xf_speed | output | 3 | Speed code for the chunk |
| cpl_valid | input | 1 | Transfer completion |
| cpl_err | input | 1 | Completion reports failure |
| cpl_code | input | 4 | Failure cause |
| st_state | output | 3 | Sequencer state |
| st_elem | output | IDX_W | Current element index |
| st_remain | output | 16 | Bytes left in the element |
| st_err | output | 4 | Last error cause |
| done | output | 1 | Run finished |
| done_pulse | output | 1 | One-cycle finish strobe |

## Verification
A command pulse is seen by the design at the edge after it is driven. A first read request is therefore visible one cycle after start. A reset command shows idle one cycle after the pulse, and a failing completion shows state 7 one cycle after it is presented. `done_pulse` arrives two edges after the last completion, plus one more edge for each trailing empty element. The bench drives and samples only on the falling edge. It presents read data one cycle after a read handshake and completions two cycles after a transfer handshake. Every handshake it observes is compared, in order, against a queue that it builds in advance from the configuration. Status values are compared only after the bench has waited for a named state, so no check depends on a guessed cycle count.

// File: rtl/pt_seq_pkg.sv
`timescale 1ns/1ps
package pt_seq_pkg;
  localparam int ADDR_W = 48;
  localparam int LEN_W  = 16;
  localparam int CODE_W = 4;
  localparam logic [3:0] ERR_OVERSIZE = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FREQ   = 3'd1,
    ST_FWAIT  = 3'd2,
    ST_LOAD   = 3'd3,
    ST_XREQ   = 3'd4,
    ST_XWAIT  = 3'd5,
    ST_PAUSE  = 3'd6,
    ST_EPAUSE = 3'd7
  } state_t;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] base;
  } seg_t;
endpackage

// File: rtl/pt_elem_store.sv
`timescale 1ns/1ps
module pt_elem_store
  import pt_seq_pkg::*;
#(
  parameter int MAX_ELEM = 24,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_lo,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_t             rd_seg
);
  seg_t ent_seg [MAX_ELEM];

  for (genvar g = 0; g < MAX_ELEM; g++) begin : g_ent
    logic [31:0] hi_word_q, lo_word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_word_q <= '0;
        lo_word_q <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        if (wr_lo) lo_word_q <= wr_data;
        else       hi_word_q <= wr_data;
      end
    end
    assign ent_seg[g] = '{len: hi_word_q[31:16], base: {hi_word_q[15:0], lo_word_q}};
  end

  always_comb begin
    if (int'(rd_idx) < MAX_ELEM) rd_seg = ent_seg[rd_idx];
    else                         rd_seg = '0;
  end
endmodule

// File: rtl/pt_chunk_calc.sv
`timescale 1ns/1ps
module pt_chunk_calc #(
  parameter int LEN_W  = 16,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] pay_code,
  input  logic [LEN_W-1:0]  remain,
  output logic [LEN_W-1:0]  chunk
);
  // Largest code whose payload 2^(code+2) still fits in LEN_W bits.
  localparam int CODE_FIT = LEN_W - 3;

  logic [LEN_W-1:0] pay;

  always_comb begin
    pay = '0;
    if (int'(pay_code) > CODE_FIT) begin
      chunk = remain;
    end else begin
      pay   = LEN_W'(1) << (int'(pay_code) + 2);
      chunk = (remain < pay) ? remain : pay;
    end
  end
endmodule

// File: rtl/pt_xfer_seq.sv
`timescale 1ns/1ps
module pt_xfer_seq
  import pt_seq_pkg::*;
#(
  parameter  int MAX_ELEM = 24,
  localparam int IDX_W    = $clog2(MAX_ELEM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_table_addr,
  input  logic [LEN_W-1:0]  cfg_table_size,
  input  logic [2:0]        cfg_speed,
  input  logic [CODE_W-1:0] cfg_pay_code,
  input  logic [IDX_W-1:0]  cfg_start_elem,
  input  logic              cfg_direct,
  input  logic              cfg_skip_fetch,
  input  logic              cmd_start,
  input  logic              cmd_pause,
  input  logic              cmd_resume,
  input  logic              cmd_reset,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_resp_valid,
  input  logic [31:0]       rd_resp_data,
  output logic              xf_valid,
  input  logic              xf_ready,
  output logic [ADDR_W-1:0] xf_addr,
  output logic [LEN_W-1:0]  xf_len,
  output logic [2:0]        xf_speed,
  input  logic              cpl_valid,
  input  logic              cpl_err,
  input  logic [3:0]        cpl_code,
  output logic [2:0]        st_state,
  output logic [IDX_W-1:0]  st_elem,
  output logic [LEN_W-1:0]  st_remain,
  output logic [3:0]        st_err,
  output logic              done,
  output logic              done_pulse
);
  localparam int FW = IDX_W + 1;   // word counter: two words per element

  state_t            state_q;
  logic [FW-1:0]     fidx_q, fidx_nx;
  logic [IDX_W-1:0]  eidx_q, nel_q;
  logic              dir_q, pend_q, done_q, dpulse_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, chunk;
  logic [3:0]        err_q;
  seg_t              st_seg, ld_seg;
  logic              store_wr, busy;

  assign store_wr = (state_q == ST_FWAIT) && rd_resp_valid;

  pt_elem_store #(.MAX_ELEM(MAX_ELEM), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_wr),
    .wr_idx  (fidx_q[FW-1:1]),
    .wr_lo   (fidx_q[0]),
    .wr_data (rd_resp_data),
    .rd_idx  (eidx_q),
    .rd_seg  (st_seg)
  );

  pt_chunk_calc #(.LEN_W(LEN_W), .CODE_W(CODE_W)) u_chunk (
    .pay_code (cfg_pay_code),
    .remain   (rem_q),
    .chunk    (chunk)
  );

  assign ld_seg  = dir_q ? '{len: cfg_table_size, base: cfg_table_addr} : st_seg;
  assign fidx_nx = fidx_q + 1'b1;
  assign busy    = (state_q != ST_IDLE) && (state_q != ST_PAUSE) && (state_q != ST_EPAUSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fidx_q   <= '0;
      eidx_q   <= '0;
      nel_q    <= '0;
      dir_q    <= 1'b0;
      pend_q   <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      err_q    <= '0;
      done_q   <= 1'b0;
      dpulse_q <= 1'b0;
    end else begin
      dpulse_q <= 1'b0;
      if (cmd_pause && busy) pend_q <= 1'b1;
      if (cmd_reset) begin
        state_q <= ST_IDLE;
        pend_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (cmd_start) begin
            if (!cfg_direct && cfg_table_size > LEN_W'(MAX_ELEM)) begin
              err_q <= ERR_OVERSIZE;
            end else begin
              err_q  <= '0;
              done_q <= 1'b0;
              pend_q <= 1'b0;
              dir_q  <= cfg_direct;
              nel_q  <= cfg_direct ? IDX_W'(1) : cfg_table_size[IDX_W-1:0];
              eidx_q <= cfg_direct ? '0 : cfg_start_elem;
              fidx_q <= '0;
              state_q <= (cfg_direct || cfg_skip_fetch || cfg_table_size == '0)
                         ? ST_LOAD : ST_FREQ;
            end
          end
          ST_FREQ: if (rd_ready) state_q <= ST_FWAIT;
          ST_FWAIT: if (rd_resp_valid) begin
            fidx_q  <= fidx_nx;
            state_q <= (fidx_nx == {nel_q, 1'b0}) ? ST_LOAD : ST_FREQ;
          end
          ST_LOAD: begin
            if (eidx_q >= nel_q) begin
              done_q   <= 1'b1;
              dpulse_q <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (ld_seg.len == '0) begin
              eidx_q <= eidx_q + 1'b1;
            end else begin
              rem_q  <= ld_seg.len;
              addr_q <= ld_seg.base;
              if (pend_q) begin
                pend_q  <= 1'b0;
                state_q <= ST_PAUSE;
              end else begin
                state_q <= ST_XREQ;
              end
            end
          end
          ST_XREQ: if (xf_ready) state_q <= ST_XWAIT;
          ST_XWAIT: if (cpl_valid) begin
            if (cpl_err) begin
              err_q   <= cpl_code;
              state_q <= ST_EPAUSE;
            end else begin
              addr_q <= addr_q + ADDR_W'(chunk);
              rem_q  <= rem_q - chunk;
              if (rem_q == chunk) begin
                eidx_q  <= eidx_q + 1'b1;
                state_q <= ST_LOAD;
              end else if (pend_q) begin
                pend_q  <= 1'b0;
                state_q <= ST_PAUSE;
              end else begin
                state_q <= ST_XREQ;
              end
            end
          end
          ST_PAUSE, ST_EPAUSE: if (cmd_resume) state_q <= ST_XREQ;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_valid   = (state_q == ST_FREQ);
  assign rd_addr    = cfg_table_addr + ADDR_W'({fidx_q, 2'b00});
  assign xf_valid   = (state_q == ST_XREQ);
  assign xf_addr    = addr_q;
  assign xf_len     = chunk;
  assign xf_speed   = cfg_speed;
  assign st_state   = state_q;
  assign st_elem    = eidx_q;
  assign st_remain  = rem_q;
  assign st_err     = err_q;
  assign done       = done_q;
  assign done_pulse = dpulse_q;
endmodule

// File: rtl/pt_xfer_seq_chk.sv
`timescale 1ns/1ps
module pt_xfer_seq_chk
  import pt_seq_pkg::*;
#(
  parameter int MAX_ELEM = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              cmd_reset,
  input logic              cfg_direct,
  input logic [LEN_W-1:0]  cfg_table_size,
  input logic [CODE_W-1:0] cfg_pay_code,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              xf_valid,
  input logic              xf_ready,
  input logic [ADDR_W-1:0] xf_addr,
  input logic [LEN_W-1:0]  xf_len,
  input logic              cpl_valid,
  input logic              cpl_err,
  input logic [2:0]        st_state,
  input logic [3:0]        st_err,
  input logic              done_pulse
);
  AST_XF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xf_valid && !xf_ready && !cmd_reset |=> xf_valid && $stable(xf_addr) && $stable(xf_len)); // R12

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !cmd_reset |=> rd_valid && $stable(rd_addr)); // R12

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && xf_valid)); // R1

  AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    xf_valid |-> (xf_len != '0) && (32'(xf_len) <= (32'd1 << (32'(cfg_pay_code) + 2)))); // R2

  AST_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && !cmd_reset && st_state == ST_IDLE && !cfg_direct
      && cfg_table_size > LEN_W'(MAX_ELEM)
    |=> st_state == ST_IDLE && st_err == ERR_OVERSIZE && !rd_valid); // R3

  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_err && st_state == ST_XWAIT && !cmd_reset
    |=> st_state == ST_EPAUSE && !xf_valid); // R7

  AST_CMD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> st_state == ST_IDLE && !xf_valid && !rd_valid); // R9

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R11
endmodule

bind pt_xfer_seq pt_xfer_seq_chk #(.MAX_ELEM(MAX_ELEM)) u_chk (.*);

// File: tb/test_pt_xfer_seq.sv
`timescale 1ns/1ps
module test_pt_xfer_seq;
  import pt_seq_pkg::*;
  localparam int MAX_ELEM = 24;
  localparam int IDX_W = $clog2(MAX_ELEM + 1);
  localparam logic [47:0] TBL = 48'h0000_0000_1000;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [47:0] cfg_table_addr = TBL;
  logic [15:0] cfg_table_size = '0;
  logic [2:0]  cfg_speed = 3'd2;
  logic [3:0]  cfg_pay_code = 4'd3;
  logic [IDX_W-1:0] cfg_start_elem = '0;
  logic cfg_direct = 1'b0, cfg_skip_fetch = 1'b0;
  logic cmd_start = 1'b0, cmd_pause = 1'b0, cmd_resume = 1'b0, cmd_reset = 1'b0;
  logic rd_valid, rd_ready = 1'b0;
  logic [47:0] rd_addr;
  logic rd_resp_valid = 1'b0;
  logic [31:0] rd_resp_data = '0;
  logic xf_valid, xf_ready = 1'b0;
  logic [47:0] xf_addr;
  logic [15:0] xf_len;
  logic [2:0]  xf_speed;
  logic cpl_valid = 1'b0, cpl_err = 1'b0;
  logic [3:0] cpl_code = '0;
  logic [2:0] st_state;
  logic [IDX_W-1:0] st_elem;
  logic [15:0] st_remain;
  logic [3:0] st_err;
  logic done, done_pulse;

  pt_xfer_seq #(.MAX_ELEM(MAX_ELEM)) i_pt_xfer_seq (.*);

  always #2.5 clk = ~clk;   // 200 MHz

  int vec = 0, fails = 0, cyc = 0;
  logic [47:0] exp_rd [$];
  logic [63:0] exp_xf [$];
  logic [31:0] mem [16];
  logic [15:0] el_len [4];
  logic [47:0] el_addr [4];
  bit rd_pend = 0, cpl_bad = 0, dp_seen = 0, prev_hold = 0;
  int rd_pidx = 0, cpl_cnt = 0, hs_num = 0, err_at = -1;
  logic [63:0] prev_item = '0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    vec++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // One falling edge: behavioural memory, completer and handshake comparison.
  task automatic tick();
    logic [63:0] item, want;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
      summary();
    end
    if (!rst_n) return;
    xf_ready = (cyc % 3) != 0;
    rd_ready = (cyc % 4) != 1;
    rd_resp_valid = rd_pend;
    if (rd_pend) rd_resp_data = mem[rd_pidx];
    rd_pend = 0;
    cpl_valid = 0; cpl_err = 0; cpl_code = 4'd0;
    if (st_state == 3'd0) cpl_cnt = 0;
    if (cpl_cnt > 0) begin
      cpl_cnt--;
      if (cpl_cnt == 0) begin
        cpl_valid = 1; cpl_err = cpl_bad; cpl_code = cpl_bad ? 4'd5 : 4'd0;
      end
    end
    item = {xf_len, xf_addr};
    // R12: a request that was not accepted must persist unchanged
    if (prev_hold) chk(xf_valid && item == prev_item, "R12 hold", item, prev_item);
    prev_hold = xf_valid && !xf_ready;
    prev_item = item;
    if (rd_valid && rd_ready) begin
      if (exp_rd.size() == 0) chk(0, "R1 unexpected read", rd_addr, 0);
      else begin
        want = {16'h0, exp_rd.pop_front()};
        chk(rd_addr == want[47:0], "R1 read address", rd_addr, want);
      end
      rd_pend = 1;
      rd_pidx = int'((rd_addr - TBL) >> 2) & 15;
    end
    if (xf_valid && xf_ready) begin
      if (exp_xf.size() == 0) begin
        chk(0, "R2 unexpected transfer", item, 0);
      end else begin
        want = exp_xf.pop_front();
        chk(item == want, "R2 chunk len/addr", item, want);
      end
      cpl_cnt = 2;
      cpl_bad = (hs_num == err_at);
      if (cpl_bad) exp_xf.push_front(item);   // R8: same chunk again after resume
      hs_num++;
    end
    if (done_pulse) begin
      dp_seen = 1;
      chk(exp_xf.size() == 0 && exp_rd.size() == 0, "R11 done before all work",
          exp_xf.size() + exp_rd.size(), 0);
    end
  endtask

  task automatic add_seg(input logic [47:0] a, input int len, input int code);
    int r = len, c, pay;
    logic [47:0] p = a;
    pay = 1 << (code + 2);
    while (r > 0) begin
      c = (r < pay) ? r : pay;
      exp_xf.push_back({16'(c), p});
      p = p + 48'(c);
      r -= c;
    end
  endtask

  task automatic plan(input bit dir, input bit skip, input int first, input int n,
                      input int code, input int dsize);
    exp_rd.delete(); exp_xf.delete(); hs_num = 0; dp_seen = 0;
    if (!dir && !skip) for (int k = 0; k < 2 * n; k++) exp_rd.push_back(TBL + 48'(4 * k));
    if (dir) add_seg(TBL, dsize, code);
    else for (int e = first; e < n; e++) add_seg(el_addr[e], int'(el_len[e]), code);
    cfg_direct = dir; cfg_skip_fetch = skip; cfg_start_elem = IDX_W'(first);
    cfg_pay_code = 4'(code); cfg_table_size = dir ? 16'(dsize) : 16'(n);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: cmd_start = 1; 1: cmd_pause = 1; 2: cmd_resume = 1; default: cmd_reset = 1;
    endcase
    tick();
    cmd_start = 0; cmd_pause = 0; cmd_resume = 0; cmd_reset = 0;
  endtask

  task automatic run_done(input string req);
    for (int i = 0; i < 4000 && !dp_seen; i++) tick();
    chk(dp_seen, req, dp_seen, 1);
    tick();
    chk(!done_pulse && done && st_state == 3'd0, "R11 pulse one cycle, flag held",
        {done_pulse, done, st_state}, {1'b0, 1'b1, 3'd0});
  endtask

  task automatic wait_state(input logic [2:0] s, input string req);
    for (int i = 0; i < 4000 && st_state != s; i++) tick();
    chk(st_state == s, req, st_state, s);
  endtask

  initial begin
    int h0;
    el_len[0] = 16'd40; el_addr[0] = 48'h0001_2000_0000;
    el_len[1] = 16'd0;  el_addr[1] = 48'h0002_0000_0100;
    el_len[2] = 16'd16; el_addr[2] = 48'h0003_0000_0040;
    el_len[3] = 16'd70; el_addr[3] = 48'h0001_FFFF_FFF0;
    for (int w = 0; w < 16; w++) mem[w] = '0;
    for (int e = 0; e < 4; e++) begin
      mem[2 * e]     = {el_len[e], el_addr[e][47:32]};
      mem[2 * e + 1] = el_addr[e][31:0];
    end

    repeat (3) tick();
    chk(st_state == 0 && !rd_valid && !xf_valid && !done && !done_pulse && st_err == 0
        && st_remain == 0 && st_elem == 0, "R13 reset state", st_state, 0);
    rst_n = 1;
    tick();

    // R1 R2: full table fetch, zero-length element 1 skipped, carry into upper address
    plan(0, 0, 0, 4, 3, 0);
    pulse(0);
    run_done("R1 R2 table run finishes");
    chk(st_elem == 4, "R10 element index after run", st_elem, 4);

    // R5: reuse stored elements, start at element 2
    plan(0, 1, 2, 4, 3, 0);
    pulse(0);
    run_done("R5 skip fetch run finishes");

    // R4: direct mode, 100 bytes in 32-byte chunks, then zero length
    plan(1, 0, 0, 1, 3, 100);
    pulse(0);
    run_done("R4 direct run finishes");
    chk(st_elem == 1, "R10 element index after direct run", st_elem, 1);
    plan(1, 0, 0, 1, 3, 0);
    pulse(0);
    run_done("R4 direct zero length finishes");

    // R3: oversize table rejected
    plan(0, 0, 0, 0, 3, 0);
    cfg_table_size = 16'd25;
    pulse(0);
    repeat (6) tick();
    chk(st_err == 4'hF && st_state == 0 && !rd_valid, "R3 oversize rejected", st_err, 4'hF);

    // R7 R8: second chunk fails, stays put, resume re-issues it
    plan(0, 1, 0, 4, 3, 0);
    err_at = 1;
    pulse(0);
    wait_state(3'd7, "R7 error pause entered");
    chk(st_err == 4'd5, "R7 cause recorded", st_err, 5);
    chk(st_elem == 0 && st_remain == 16'd8, "R10 status at error", st_remain, 8);
    repeat (5) tick();
    chk(!xf_valid && st_state == 3'd7, "R7 no request while paused", xf_valid, 0);
    err_at = -1;
    pulse(2);
    run_done("R8 resume completes run");

    // R6: pause during first completion wait of a 200-byte direct run
    plan(1, 0, 0, 1, 3, 200);
    pulse(0);
    wait_state(3'd5, "R6 reached transfer wait");
    pulse(1);
    h0 = hs_num;
    repeat (12) tick();
    chk(st_state == 3'd6, "R6 paused at boundary", st_state, 6);
    chk(hs_num == h0, "R6 no new request while paused", hs_num, h0);
    chk(st_remain == 16'd168, "R10 remaining after one chunk", st_remain, 168);
    pulse(2);
    run_done("R6 resume completes run");

    // R9: reset from error pause keeps status
    plan(1, 0, 0, 1, 2, 1000);
    err_at = 2;
    pulse(0);
    wait_state(3'd7, "R7 error pause before reset");
    chk(st_remain == 16'd968, "R10 remaining at failed chunk", st_remain, 968);
    pulse(3);
    chk(st_state == 0 && st_err == 4'd5 && st_remain == 16'd968 && st_elem == 0,
        "R9 idle with status kept", {st_state, st_err, st_remain}, {3'd0, 4'd5, 16'd968});
    repeat (5) tick();
    chk(!xf_valid && !rd_valid && st_state == 0, "R9 stays idle", xf_valid, 0);
    err_at = -1;

    // R5 R2: stored elements survive the reset command, larger payload
    plan(0, 1, 1, 4, 5, 0);
    pulse(0);
    run_done("R5 run after reset finishes");

    summary();
  end
endmodule